// File: doc/BRIEF.md
# Flash Program/Erase Host Sequencer

This block sits between an on-chip requester and an external byte-wide parallel flash device with an asynchronous bus (active-low chip select, output enable and write strobe, an address bus and a data bus). A request names one of four operations: a single-byte read, a byte program, a sector erase or a chip erase. For the three write-type operations the block drives the required unlock write sequence and then polls the device over the same bus until the internal operation finishes. It reports the outcome on a one-cycle response.

All bus timing is derived from a clock-period parameter. The write strobe low time, the strobe high time between writes and the read access time are each given in nanoseconds and converted to whole clock cycles, rounding up. Completion is detected by reading the target location in pairs and comparing the toggling status bit (bit 6). A pair that looks finished is confirmed by two more reads. This rejects a false result when a read lands exactly on the moment the device finishes. A per-operation timeout, also given in nanoseconds, bounds the wait. A program result is checked against the requested byte.

The data bus is split into an output, an output enable and an input, so the pad tristate sits outside the block. Operation codes on `req_op` are 0 for read, 1 for program, 2 for sector erase and 3 for chip erase. Status codes on `rsp_status` are 0 for success, 1 for a program verify mismatch and 2 for timeout.

Top module: `flash_seq_top`

## Requirements
- R1: A program request (op 1) issues exactly four bus writes, as address/data pairs in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the request address with the request data.
- R2: A sector erase (op 2) issues six writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then the request address/0x20. A chip erase (op 3) issues the same first five writes, then 0x555/0x10.
- R3: In every write, the write strobe is low for at least ceil(40 ns / clock period) cycles, with chip select low, output enable high and the data output enabled. Address and data stay stable while the strobe is low. Between writes of one sequence, the strobe stays high for at least ceil(30 ns / clock period) cycles.
- R4: For every read, the data output enable is already low in the cycle before output enable falls. Output enable stays low for ceil(ACCESS_NS / clock period) cycles (default 55 ns), and the byte is captured at the end of that window.
- R5: After the last write, the request address is read in pairs. Only bit 6 of the two bytes is compared. If the bits differ, another pair is read. If they are equal, confirmation begins.
- R6: Confirmation reads the location twice more. Completion is accepted only if those two bytes are identical; otherwise pair polling resumes.
- R7: On an accepted program, the last byte read is compared with the requested data. A mismatch gives status 1, a match status 0. Erases give status 0. `rsp_rdata` carries the last byte read.
- R8: If the timeout (ceil of 20 µs, 25 ms or 100 ms over the clock period, for program, sector erase and chip erase, counted from completion of the last write) has elapsed when a poll pair or confirmation fails, the block responds with status 2.
- R9: `req_ready` is high only when no request is in flight. Each accepted request gets exactly one single-cycle `rsp_valid` pulse, and no request is accepted between acceptance and that pulse.
- R10: A read request (op 0) performs one bus read at the request address, with no writes, and responds with status 0 and the byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte or sector address |
| req_wdata | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 success, 1 verify mismatch, 2 timeout |
| rsp_rdata | output | 8 | Last byte read from the device |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data pad drivers |
| fl_dq_i | input | 8 | Data returned by the flash |

## Verification
A wrong step counter or command decode shows up within one write period as a misplaced address/data pair on the bus. The bench records every strobe edge and compares the sequence against the expected list. A poll or confirm state that compares the wrong bits, or returns to the wrong place, changes how many reads are issued before the response. The scripted device answers make that count exact for each case, so the error is visible at the response strobe. A broken timeout or verify path shows as a wrong status code on the first response after the fault.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } fop_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_VERIFY  = 2'd1,
        RS_TIMEOUT = 2'd2
    } fres_e;

    // nanoseconds to clock cycles, rounded up
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  fop_e              op,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [ADDR_W-1:0] w_addr,
    output logic [7:0]        w_data,
    output logic              w_last
);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12'h2AA);

    always_comb begin
        w_addr = A_HI;
        w_data = 8'hAA;
        w_last = 1'b0;
        if (op == OP_PROG) begin
            w_last = (step == 3'd3);
            unique case (step)
                3'd0:    begin w_addr = A_HI;     w_data = 8'hAA;    end
                3'd1:    begin w_addr = A_LO;     w_data = 8'h55;    end
                3'd2:    begin w_addr = A_HI;     w_data = 8'hA0;    end
                default: begin w_addr = tgt_addr; w_data = tgt_data; end
            endcase
        end else begin
            w_last = (step == 3'd5);
            unique case (step)
                3'd0, 3'd3: begin w_addr = A_HI; w_data = 8'hAA; end
                3'd1, 3'd4: begin w_addr = A_LO; w_data = 8'h55; end
                3'd2:       begin w_addr = A_HI; w_data = 8'h80; end
                default: begin
                    w_addr = (op == OP_SECT) ? tgt_addr : A_HI;
                    w_data = (op == OP_SECT) ? 8'h20 : 8'h10;
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_seq_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int PROG_TO_NS = 20_000,
    parameter int SE_TO_NS   = 25_000_000,
    parameter int CE_TO_NS   = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  fop_e op,
    output logic expired
);
    localparam int PROG_CYC = ns2cyc(PROG_TO_NS, CLK_NS);
    localparam int SE_CYC   = ns2cyc(SE_TO_NS, CLK_NS);
    localparam int CE_CYC   = ns2cyc(CE_TO_NS, CLK_NS);
    localparam int MAX_CYC  = imax(PROG_CYC, imax(SE_CYC, CE_CYC));
    localparam int TW       = $clog2(MAX_CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        unique case (op)
            OP_SECT: limit = TW'(SE_CYC);
            OP_CHIP: limit = TW'(CE_CYC);
            default: limit = TW'(PROG_CYC);
        endcase
        if (start)               cnt_d = limit;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R8
    expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> expired);
    // R8
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !expired);
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int WL_CYC  = 4,
    parameter int WH_CYC  = 3,
    parameter int ACC_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        dq_o,
    output logic              dq_oe,
    input  logic [7:0]        dq_i
);
    localparam int CMAX = imax(WL_CYC, imax(WH_CYC, ACC_CYC));
    localparam int CW   = (CMAX < 2) ? 1 : $clog2(CMAX);

    typedef enum logic [2:0] {B_IDLE, B_WLOW, B_WHIGH, B_RTURN, B_RWAIT} bst_e;

    typedef struct packed {
        bst_e              st;
        logic [CW-1:0]     cnt;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        dq_o;
        logic              dq_oe;
        logic [7:0]        rdata;
        logic              done;
    } bus_s;

    bus_s d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            B_IDLE: if (start) begin
                d.addr = addr;
                d.ce_n = 1'b0;
                d.oe_n = 1'b1;
                if (wr) begin
                    d.st    = B_WLOW;
                    d.we_n  = 1'b0;
                    d.dq_o  = wdata;
                    d.dq_oe = 1'b1;
                    d.cnt   = CW'(WL_CYC - 1);
                end else begin
                    d.st    = B_RTURN;
                    d.dq_oe = 1'b0;
                end
            end
            B_WLOW: if (q.cnt == '0) begin
                d.st   = B_WHIGH;
                d.we_n = 1'b1;
                d.cnt  = CW'(WH_CYC - 1);
            end else d.cnt = q.cnt - 1'b1;
            B_WHIGH: if (q.cnt == '0) begin
                d.st    = B_IDLE;
                d.ce_n  = 1'b1;
                d.dq_oe = 1'b0;
                d.done  = 1'b1;
            end else d.cnt = q.cnt - 1'b1;
            B_RTURN: begin
                d.st   = B_RWAIT;
                d.oe_n = 1'b0;
                d.cnt  = CW'(ACC_CYC - 1);
            end
            B_RWAIT: if (q.cnt == '0) begin
                d.st    = B_IDLE;
                d.rdata = dq_i;
                d.oe_n  = 1'b1;
                d.ce_n  = 1'b1;
                d.done  = 1'b1;
            end else d.cnt = q.cnt - 1'b1;
            default: d.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= B_IDLE;
            q.ce_n  <= 1'b1;
            q.oe_n  <= 1'b1;
            q.we_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign rdata    = q.rdata;
    assign ce_n     = q.ce_n;
    assign oe_n     = q.oe_n;
    assign we_n     = q.we_n;
    assign bus_addr = q.addr;
    assign dq_o     = q.dq_o;
    assign dq_oe    = q.dq_oe;

    // R3
    write_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n && dq_oe));
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n)) |-> ($stable(bus_addr) && $stable(dq_o)));
    // R4
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && !$past(dq_oe)));
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int CLK_NS     = 10,
    parameter int WE_LOW_NS  = 40,
    parameter int WE_HIGH_NS = 30,
    parameter int ACCESS_NS  = 55,
    parameter int PROG_TO_NS = 20_000,
    parameter int SE_TO_NS   = 25_000_000,
    parameter int CE_TO_NS   = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [7:0]        rsp_rdata,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_i
);
    localparam int WL_CYC  = imax(1, ns2cyc(WE_LOW_NS, CLK_NS));
    localparam int WH_CYC  = imax(1, ns2cyc(WE_HIGH_NS, CLK_NS));
    localparam int ACC_CYC = imax(1, ns2cyc(ACCESS_NS, CLK_NS));

    typedef enum logic [2:0] {S_IDLE, S_CMD, S_READ, S_POLL, S_CONF} sst_e;

    typedef struct packed {
        sst_e              st;
        fop_e              op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic [2:0]        step;
        logic              rd_idx;
        logic [7:0]        first;
        logic              pend;
        logic              rsp_valid;
        fres_e             rsp_status;
        logic [7:0]        rsp_rdata;
    } top_s;

    top_s d, q;

    logic              bus_start, bus_wr, bus_done;
    logic [ADDR_W-1:0] bus_req_addr, rom_addr;
    logic [7:0]        bus_rdata, rom_data;
    logic              rom_last, tmr_start, tmr_exp;

    flash_cmd_rom #(.ADDR_W(ADDR_W)) u_rom (
        .op(q.op), .step(q.step), .tgt_addr(q.addr), .tgt_data(q.wdata),
        .w_addr(rom_addr), .w_data(rom_data), .w_last(rom_last)
    );

    flash_op_timer #(
        .CLK_NS(CLK_NS), .PROG_TO_NS(PROG_TO_NS),
        .SE_TO_NS(SE_TO_NS), .CE_TO_NS(CE_TO_NS)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .op(q.op), .expired(tmr_exp)
    );

    flash_bus_cycle #(
        .ADDR_W(ADDR_W), .WL_CYC(WL_CYC), .WH_CYC(WH_CYC), .ACC_CYC(ACC_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .wr(bus_wr),
        .addr(bus_req_addr), .wdata(rom_data), .done(bus_done), .rdata(bus_rdata),
        .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .bus_addr(fl_addr),
        .dq_o(fl_dq_o), .dq_oe(fl_dq_oe), .dq_i(fl_dq_i)
    );

    always_comb begin
        bus_start    = !q.pend && (q.st != S_IDLE);
        bus_wr       = (q.st == S_CMD);
        bus_req_addr = bus_wr ? rom_addr : q.addr;
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        tmr_start   = 1'b0;
        if (bus_start) d.pend = 1'b1;
        if (bus_done)  d.pend = 1'b0;
        unique case (q.st)
            S_IDLE: if (req_valid) begin
                d.op     = fop_e'(req_op);
                d.addr   = req_addr;
                d.wdata  = req_wdata;
                d.step   = '0;
                d.rd_idx = 1'b0;
                d.st     = (fop_e'(req_op) == OP_READ) ? S_READ : S_CMD;
            end
            S_CMD: if (bus_done) begin
                if (rom_last) begin
                    d.st      = S_POLL;
                    d.rd_idx  = 1'b0;
                    tmr_start = 1'b1;
                end else begin
                    d.step = q.step + 3'd1;
                end
            end
            S_READ: if (bus_done) begin
                d.rsp_valid  = 1'b1;
                d.rsp_status = RS_OK;
                d.rsp_rdata  = bus_rdata;
                d.st         = S_IDLE;
            end
            S_POLL: if (bus_done) begin
                if (!q.rd_idx) begin
                    d.first  = bus_rdata;
                    d.rd_idx = 1'b1;
                end else begin
                    d.rd_idx = 1'b0;
                    if (q.first[6] == bus_rdata[6]) begin
                        d.st = S_CONF;
                    end else if (tmr_exp) begin
                        d.rsp_valid  = 1'b1;
                        d.rsp_status = RS_TIMEOUT;
                        d.rsp_rdata  = bus_rdata;
                        d.st         = S_IDLE;
                    end
                end
            end
            S_CONF: if (bus_done) begin
                if (!q.rd_idx) begin
                    d.first  = bus_rdata;
                    d.rd_idx = 1'b1;
                end else begin
                    d.rd_idx = 1'b0;
                    if (q.first == bus_rdata) begin
                        d.rsp_valid  = 1'b1;
                        d.rsp_status = (q.op == OP_PROG && bus_rdata != q.wdata)
                                       ? RS_VERIFY : RS_OK;
                        d.rsp_rdata  = bus_rdata;
                        d.st         = S_IDLE;
                    end else if (tmr_exp) begin
                        d.rsp_valid  = 1'b1;
                        d.rsp_status = RS_TIMEOUT;
                        d.rsp_rdata  = bus_rdata;
                        d.st         = S_IDLE;
                    end else begin
                        d.st = S_POLL;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.st         <= S_IDLE;
            q.op         <= OP_READ;
            q.rsp_status <= RS_OK;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == S_IDLE);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_status = q.rsp_status;
    assign rsp_rdata  = q.rsp_rdata;

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_READ) |-> fl_we_n);
endmodule

// File: tb/sim_flash_seq_top.sv
module sim_flash_seq_top;
    localparam int CLK_NS  = 10;
    localparam int AW      = 19;
    localparam int WL      = 4;
    localparam int WH      = 3;
    localparam int ACC     = 6;
    localparam int PROG_TO = 2000;
    localparam int PROG_CY = PROG_TO / CLK_NS;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic          rst_n, req_valid, req_ready, rsp_valid;
    logic [1:0]    req_op, rsp_status;
    logic [AW-1:0] req_addr, fl_addr;
    logic [7:0]    req_wdata, rsp_rdata, fl_dq_o, dq_i_r;
    logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;

    flash_seq_top #(
        .ADDR_W(AW), .CLK_NS(CLK_NS), .ACCESS_NS(55),
        .PROG_TO_NS(PROG_TO), .SE_TO_NS(5000), .CE_TO_NS(8000)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
        .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(dq_i_r)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [26:0] wq[$], exp_wq[$];
    logic [7:0]  script[$];
    bit   toggle_mode = 0, tog = 0, req_busy = 0, ready_bad = 0, finished = 0;
    int   n_reads = 0, low_cnt = 0, high_cnt = 100, oe_cnt = 0, last_rise = 0;
    logic prev_we = 1, prev_oe = 1, prev_dqoe = 0;
    logic [AW-1:0] cap_addr;
    logic [7:0]    cap_data;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // behavioural device and bus monitor, evaluated every clock away from the edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_we = 1; prev_oe = 1; prev_dqoe = 0; dq_i_r = 8'h00;
        end else begin
            if (prev_we && !fl_we_n) begin
                chk(!fl_ce_n && fl_oe_n && fl_dq_oe, "R3", "write pins", 0, 0);
                if (wq.size() > 0) chk(high_cnt >= WH, "R3", "strobe high gap", high_cnt, WH);
                low_cnt = 1; cap_addr = fl_addr; cap_data = fl_dq_o;
            end else if (!prev_we && !fl_we_n) begin
                low_cnt++;
                if (fl_addr != cap_addr || fl_dq_o != cap_data)
                    chk(0, "R3", "addr/data moved in strobe", int'(fl_addr), int'(cap_addr));
            end else if (!prev_we && fl_we_n) begin
                chk(low_cnt >= WL, "R3", "strobe low width", low_cnt, WL);
                wq.push_back({cap_addr, cap_data});
                high_cnt = 1; last_rise = cyc;
            end else high_cnt++;

            if (prev_oe && !fl_oe_n) begin
                chk(!fl_dq_oe && !prev_dqoe && !fl_ce_n && fl_we_n, "R4", "bus release", 0, 0);
                oe_cnt = 1;
                if (toggle_mode) begin dq_i_r = {1'b0, tog, 6'h0}; tog = ~tog; end
                else if (script.size() > 0) dq_i_r = script.pop_front();
                else dq_i_r = 8'hA5;
            end else if (!prev_oe && !fl_oe_n) oe_cnt++;
            else if (!prev_oe && fl_oe_n) begin
                chk(oe_cnt >= ACC, "R4", "access window", oe_cnt, ACC);
                n_reads++;
            end
            if (req_busy && req_ready) ready_bad = 1;
            prev_we = fl_we_n; prev_oe = fl_oe_n; prev_dqoe = fl_dq_oe;
        end
    end

    task automatic exp_seq(input int op, input int a, input int wd);
        exp_wq.delete();
        exp_wq.push_back({19'h555, 8'hAA});
        exp_wq.push_back({19'h2AA, 8'h55});
        if (op == 1) begin
            exp_wq.push_back({19'h555, 8'hA0});
            exp_wq.push_back({AW'(a), 8'(wd)});
        end else begin
            exp_wq.push_back({19'h555, 8'h80});
            exp_wq.push_back({19'h555, 8'hAA});
            exp_wq.push_back({19'h2AA, 8'h55});
            if (op == 2) exp_wq.push_back({AW'(a), 8'h20});
            else         exp_wq.push_back({19'h555, 8'h10});
        end
    endtask

    int rsp_cyc;

    task automatic run(input int op, input int a, input int wd, input int exp_st,
                       input int exp_rd, input int exp_reads, input string rq);
        int n;
        wq.delete(); n_reads = 0; ready_bad = 0;
        if (op != 0) exp_seq(op, a, wd); else exp_wq.delete();
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_addr = AW'(a); req_wdata = 8'(wd);
        n = 0;
        while (!req_ready && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 0; req_busy = 1;
        n = 0;
        while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
        rsp_cyc = cyc;
        req_busy = 0;
        chk(rsp_valid, rq, "response seen", int'(rsp_valid), 1);
        chk(rsp_status == 2'(exp_st), rq, "status", int'(rsp_status), exp_st);
        if (exp_rd >= 0) chk(rsp_rdata == 8'(exp_rd), rq, "rdata", int'(rsp_rdata), exp_rd);
        if (exp_reads >= 0) chk(n_reads == exp_reads, rq, "read count", n_reads, exp_reads);
        chk(!ready_bad, "R9", "ready while busy", int'(ready_bad), 0);
        chk(wq.size() == exp_wq.size(), rq, "write count", wq.size(), exp_wq.size());
        foreach (exp_wq[i])
            if (i < wq.size())
                chk(wq[i] == exp_wq[i], rq, "write pair", int'(wq[i]), int'(exp_wq[i]));
        @(negedge clk);
        chk(!rsp_valid, "R9", "single-cycle response", int'(rsp_valid), 0);
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(req_ready && !rsp_valid, "R9", "reset ready/resp", int'(req_ready), 1);
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R4", "reset bus idle", 0, 0);

        // R10 single reads
        script = '{8'hC3};
        run(0, 'h1234, 0, 0, 'hC3, 1, "R10");
        script = '{8'h00};
        run(0, 'h7FFFF, 0, 0, 'h00, 1, "R10");

        // R1 R5 R6 program: busy pair, finished pair, confirm
        script = '{8'h40, 8'h00, 8'h5E, 8'h5E, 8'h5E, 8'h5E};
        run(1, 'h0ABCD, 'h5E, 0, 'h5E, 6, "R1");

        // R7 verify mismatch
        script = '{8'h11, 8'h11, 8'h11, 8'h11};
        run(1, 'h00042, 'h22, 1, 'h11, 4, "R7");

        // R6 race: confirm pair disagrees, polling resumes
        script = '{8'h40, 8'h40, 8'h40, 8'h00, 8'h77, 8'h77, 8'h77, 8'h77};
        run(1, 'h00100, 'h77, 0, 'h77, 8, "R6");

        // R2 R5 sector erase: only bit 6 decides a pair
        script = '{8'h00, 8'h40, 8'h7F, 8'h40, 8'hFF, 8'hFF};
        run(2, 'h03F80, 0, 0, 'hFF, 6, "R5");

        // R2 chip erase
        script = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run(3, 'h00000, 0, 0, 'hFF, 4, "R2");

        // R8 timeout on a never-finishing program
        toggle_mode = 1;
        run(1, 'h00055, 'h33, 2, -1, -1, "R8");
        chk(rsp_cyc - last_rise >= PROG_CY, "R8", "timeout not early", rsp_cyc - last_rise, PROG_CY);
        chk(rsp_cyc - last_rise <= PROG_CY + 60, "R8", "timeout not late", rsp_cyc - last_rise, PROG_CY + 60);
        toggle_mode = 0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule